// File: doc/BRIEF.md
# DMA Channel Activation Sequencer

This block sits in front of a DMA transfer engine and decides which channel runs next. Each channel can be woken in two ways: a hardware service request from a peripheral, or a software start strobe raised when software sets the start flag in that channel's descriptor. Both kinds of wake-up are captured in a register stage and merged into one pending bit per channel. A fixed-priority arbiter picks the lowest-numbered pending channel.

Once a channel wins, the block reads that channel's 256-bit descriptor from a local memory that is 64 bits wide and has a one-cycle synchronous read. It issues four back-to-back reads and assembles the returned words into one descriptor. It then offers the descriptor with a valid/ready handshake. While the engine reports busy, or while an offered descriptor has not yet been taken, no new arbitration starts. Requests keep being captured during that time.

The activation timing is fixed. If a request is raised in cycle N on an idle block, the first descriptor read goes out in cycle N+3 and the descriptor is offered in cycle N+8.

Top module: `dma_act_seq`

## Requirements
- R1: A hardware request on an enabled channel, high in cycle N while the block is idle and not busy, causes the first descriptor read in cycle N+3 and no read in cycles N+1 or N+2.
- R2: A hardware request on a channel whose enable bit is low is discarded. No descriptor read and no offer ever follow from it.
- R3: A software start strobe high in cycle N is qualified whatever the enable bit says, with the same timing as R1.
- R4: When several channels are pending, they are served one at a time in ascending channel index (index 0 has the highest priority).
- R5: A pending request stays pending until its channel is granted. A repeat request, or a hardware request and a software start for the same channel together, while the channel is pending, produce exactly one service (four reads, one offer).
- R6: A service reads the memory for exactly four consecutive cycles. The address is channel*4 + k for word k = 0,1,2,3 in that order.
- R7: The memory returns data one cycle after each read. The descriptor is offered (desc_valid high) in cycle N+8, with desc_chan equal to the channel and word k placed in desc_data bits 64k+63:64k.
- R8: An offered descriptor stays valid and unchanged until desc_ready is high in the same cycle. No descriptor read happens while it is offered.
- R9: While engine_busy is high, no new arbitration starts, but requests are still recorded. A pending request is granted in the cycle busy falls, so its first read appears in the next cycle.
- R10: A synchronous active-low reset clears all pending requests, stops any fetch in progress and drops desc_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | NCH | Hardware service request per channel |
| sw_start | input | NCH | Software start strobe per channel |
| ch_enable | input | NCH | Hardware request enable per channel |
| engine_busy | input | 1 | Transfer engine busy, blocks new arbitration |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_addr | output | log2(NCH)+2 | Descriptor memory word address {channel, word} |
| mem_rdata | input | 64 | Read data, valid the cycle after mem_rd_en |
| desc_valid | output | 1 | Assembled descriptor offered |
| desc_ready | input | 1 | Engine accepts the offered descriptor |
| desc_chan | output | log2(NCH) | Channel of the offered descriptor |
| desc_data | output | 256 | Assembled descriptor, word 0 in bits 63:0 |

## Verification
The hardest case to reach from the ports is a channel that is already pending and gets hit again. This includes a repeat hardware pulse, and a hardware request together with a software start in the same cycle. In normal flow the window is too short, because a request is granted two cycles after it is raised. The bench therefore holds engine_busy high to freeze arbitration, sends several overlapping wake-ups to one channel, then releases busy. It checks that the grant happens in the same cycle and that exactly one four-read burst and one offer follow. A second stimulus raises a lower-numbered request while a descriptor is being offered and held. This shows that priority only applies at the next free arbitration slot.

// File: rtl/dma_act_pkg.sv
package dma_act_pkg;

    localparam int WORD_W = 64;
    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int DESC_W = WORD_W * BEATS;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_OFFER = 2'd3
    } fetch_st_e;

endpackage

// File: rtl/dma_act_qual.sv
module dma_act_qual #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hw_req,
    input  logic [NCH-1:0] sw_start,
    input  logic [NCH-1:0] ch_enable,
    input  logic           take,
    input  logic [CW-1:0]  take_idx,
    output logic [NCH-1:0] pend
);

    typedef struct packed {
        logic [NCH-1:0] hw;
        logic [NCH-1:0] sw;
        logic [NCH-1:0] pend;
    } qual_t;

    qual_t q_q, q_d;
    logic [NCH-1:0] clr_mask;

    always_comb begin
        q_d      = q_q;
        clr_mask = '0;
        if (take) clr_mask[take_idx] = 1'b1;
        q_d.hw   = hw_req;
        q_d.sw   = sw_start;
        q_d.pend = (q_q.pend & ~clr_mask) | (q_q.hw & ch_enable) | q_q.sw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign pend = q_q.pend;

    // R4: a grant only ever names a channel that is pending
    p_take_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> q_q.pend[take_idx]);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_hold
            // R5: pending survives until granted
            p_pend_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
                q_q.pend[i] && !(take && (take_idx == CW'(i))) |=> q_q.pend[i]);
        end
    endgenerate

endmodule

// File: rtl/dma_act_arb.sv
module dma_act_arb #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0] pend,
    output logic           any,
    output logic [CW-1:0]  win
);

    always_comb begin
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) win = CW'(i);
        end
        any = |pend;
    end

endmodule

// File: rtl/dma_act_fetch.sv
module dma_act_fetch
    import dma_act_pkg::*;
#(
    parameter int CW = 3,
    parameter int AW = CW + BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any,
    input  logic [CW-1:0]     win,
    input  logic              engine_busy,
    output logic              take,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [CW-1:0]     desc_chan,
    output logic [DESC_W-1:0] desc_data
);

    typedef struct packed {
        fetch_st_e         st;
        logic [CW-1:0]     ch;
        logic [BEAT_W-1:0] beat;
        logic              rvld;
        logic [BEAT_W-1:0] ridx;
        logic [DESC_W-1:0] desc;
    } fetch_t;

    fetch_t q_q, q_d;

    always_comb begin
        q_d    = q_q;
        take   = 1'b0;
        q_d.rvld = (q_q.st == ST_READ);
        q_d.ridx = q_q.beat;
        if (q_q.rvld) q_d.desc[int'(q_q.ridx) * WORD_W +: WORD_W] = mem_rdata;
        case (q_q.st)
            ST_IDLE: begin
                if (any && !engine_busy) begin
                    take     = 1'b1;
                    q_d.ch   = win;
                    q_d.beat = '0;
                    q_d.st   = ST_READ;
                end
            end
            ST_READ: begin
                q_d.beat = q_q.beat + 1'b1;
                if (q_q.beat == BEAT_W'(BEATS - 1)) q_d.st = ST_DRAIN;
            end
            ST_DRAIN: q_d.st = ST_OFFER;
            ST_OFFER: if (desc_ready) q_d.st = ST_IDLE;
            default:  q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign mem_rd_en  = (q_q.st == ST_READ);
    assign mem_addr   = {q_q.ch, q_q.beat};
    assign desc_valid = (q_q.st == ST_OFFER);
    assign desc_chan  = q_q.ch;
    assign desc_data  = q_q.desc;

    // R6: each burst is exactly four reads long
    p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |=> mem_rd_en ##1 mem_rd_en ##1 mem_rd_en ##1 !mem_rd_en);

    // R6: addresses step by one inside a burst
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + AW'(1));

    // R7: offer appears one idle cycle after the last read
    p_offer_after_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_valid) |-> !$past(mem_rd_en) && $past(mem_rd_en, 2));

    // R8: offered descriptor is held until accepted
    p_offer_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_data) && $stable(desc_chan));

    // R8: no reads while a descriptor is offered
    p_no_read_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> !mem_rd_en);

    // R9: a busy engine keeps an idle fetcher idle
    p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_en && engine_busy |=> !mem_rd_en);

    // R10: reset leaves the outputs quiet
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> !desc_valid && !mem_rd_en);

endmodule

// File: rtl/dma_act_seq.sv
module dma_act_seq
    import dma_act_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             hw_req,
    input  logic [NCH-1:0]             sw_start,
    input  logic [NCH-1:0]             ch_enable,
    input  logic                       engine_busy,
    output logic                       mem_rd_en,
    output logic [$clog2(NCH)+1:0]     mem_addr,
    input  logic [63:0]                mem_rdata,
    output logic                       desc_valid,
    input  logic                       desc_ready,
    output logic [$clog2(NCH)-1:0]     desc_chan,
    output logic [255:0]               desc_data
);

    localparam int CW = $clog2(NCH);
    localparam int AW = CW + BEAT_W;

    logic [NCH-1:0] pend;
    logic           any;
    logic [CW-1:0]  win;
    logic           take;

    dma_act_qual #(.NCH(NCH), .CW(CW)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_req    (hw_req),
        .sw_start  (sw_start),
        .ch_enable (ch_enable),
        .take      (take),
        .take_idx  (win),
        .pend      (pend)
    );

    dma_act_arb #(.NCH(NCH), .CW(CW)) u_arb (
        .pend (pend),
        .any  (any),
        .win  (win)
    );

    dma_act_fetch #(.CW(CW), .AW(AW)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .any         (any),
        .win         (win),
        .engine_busy (engine_busy),
        .take        (take),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .desc_valid  (desc_valid),
        .desc_ready  (desc_ready),
        .desc_chan   (desc_chan),
        .desc_data   (desc_data)
    );

endmodule

// File: tb/tb_dma_act_seq.sv
module tb_dma_act_seq;

    localparam int NCH = 4;
    localparam int CW  = 2;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] hw_req = '0;
    logic [NCH-1:0] sw_start = '0;
    logic [NCH-1:0] ch_enable = '0;
    logic           engine_busy = 1'b0;
    logic           mem_rd_en;
    logic [AW-1:0]  mem_addr;
    logic [63:0]    mem_rdata = '0;
    logic           desc_valid;
    logic           desc_ready = 1'b0;
    logic [CW-1:0]  desc_chan;
    logic [255:0]   desc_data;

    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;

    always #4 clk = ~clk;

    dma_act_seq #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start),
        .ch_enable(ch_enable), .engine_busy(engine_busy),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_chan(desc_chan), .desc_data(desc_data)
    );

    function automatic logic [63:0] pat(input int a);
        logic [15:0] m;
        m = 16'(a * 40503);
        return {8'hC3, 8'(a), m, 32'(a) ^ 32'h5A5A_F00F};
    endfunction

    function automatic logic [255:0] exp_desc(input int ch);
        return {pat(ch*4+3), pat(ch*4+2), pat(ch*4+1), pat(ch*4)};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(int'(mem_addr));
    always @(negedge clk) if (mem_rd_en) rd_cnt++;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic serve(input int ch, input string req);
        bit seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (desc_valid) seen = 1;
            else tick();
        end
        chk(seen, req, 256'(desc_valid), 256'(1));
        chk(desc_chan == CW'(ch), req, 256'(desc_chan), 256'(ch));
        chk(desc_data == exp_desc(ch), req, desc_data, exp_desc(ch));
        desc_ready = 1'b1;
        tick();
        desc_ready = 1'b0;
    endtask

    task automatic timed(input int ch, input bit use_sw, input string req);
        if (use_sw) sw_start[ch] = 1'b1; else hw_req[ch] = 1'b1;
        tick();
        sw_start = '0; hw_req = '0;
        chk(!mem_rd_en, req, 256'(mem_rd_en), 256'(0));
        tick();
        chk(!mem_rd_en, req, 256'(mem_rd_en), 256'(0));
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(mem_rd_en && mem_addr == AW'(ch*4+k), "R6",
                256'({mem_rd_en, mem_addr}), 256'({1'b1, AW'(ch*4+k)}));
        end
        tick();
        chk(!mem_rd_en && !desc_valid, "R7", 256'({mem_rd_en, desc_valid}), 256'(0));
        tick();
        serve(ch, "R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int r0;
        logic [255:0] held;
        @(negedge clk);
        tick();
        // R10: reset state
        chk(!desc_valid && !mem_rd_en, "R10", 256'({desc_valid, mem_rd_en}), 256'(0));
        rst_n = 1'b1;
        tick();

        // R1 / R7: hardware timing on each channel
        ch_enable = '1;
        for (int c = 0; c < NCH; c++) timed(c, 1'b0, "R1");
        // R3: software start with enable cleared
        ch_enable = '0;
        for (int c = 0; c < NCH; c++) timed(c, 1'b1, "R3");

        // R2: disabled hardware requests dropped
        r0 = rd_cnt;
        hw_req = '1;
        tick();
        hw_req = '0;
        repeat (15) begin
            tick();
            chk(!desc_valid, "R2", 256'(desc_valid), 256'(0));
        end
        chk(rd_cnt == r0, "R2", 256'(rd_cnt - r0), 256'(0));

        // R4: every request mask served in ascending order
        ch_enable = '1;
        for (int m = 1; m < (1 << NCH); m++) begin
            r0 = rd_cnt;
            hw_req = NCH'(m);
            tick();
            hw_req = '0;
            for (int c = 0; c < NCH; c++) if (m[c]) serve(c, "R4");
            repeat (4) tick();
            chk(rd_cnt - r0 == 4 * $countones(NCH'(m)), "R4",
                256'(rd_cnt - r0), 256'(4 * $countones(NCH'(m))));
        end

        // R5 / R9: overlapping wake-ups while busy
        engine_busy = 1'b1;
        r0 = rd_cnt;
        hw_req[2] = 1'b1; tick(); hw_req = '0; tick();
        hw_req[2] = 1'b1; sw_start[2] = 1'b1; tick();
        hw_req = '0; sw_start = '0; tick();
        hw_req[2] = 1'b1; tick(); hw_req = '0;
        repeat (4) tick();
        chk(rd_cnt == r0 && !desc_valid, "R9", 256'(rd_cnt - r0), 256'(0));
        engine_busy = 1'b0;
        tick();
        chk(mem_rd_en && mem_addr == AW'(8), "R9", 256'({mem_rd_en, mem_addr}),
            256'({1'b1, AW'(8)}));
        serve(2, "R5");
        repeat (15) begin
            tick();
            chk(!desc_valid, "R5", 256'(desc_valid), 256'(0));
        end
        chk(rd_cnt - r0 == 4, "R5", 256'(rd_cnt - r0), 256'(4));

        // R8: offer held while a higher-priority request waits
        hw_req[1] = 1'b1; tick(); hw_req = '0; tick();
        hw_req[0] = 1'b1; tick(); hw_req = '0;
        while (!desc_valid) tick();
        held = desc_data;
        chk(desc_chan == CW'(1), "R8", 256'(desc_chan), 256'(1));
        r0 = rd_cnt;
        repeat (10) begin
            tick();
            chk(desc_valid && desc_data == held && desc_chan == CW'(1), "R8",
                desc_data, held);
        end
        chk(rd_cnt == r0, "R8", 256'(rd_cnt - r0), 256'(0));
        serve(1, "R8");
        serve(0, "R4");

        // R10: reset drops a pending request
        engine_busy = 1'b1;
        hw_req[3] = 1'b1; tick(); hw_req = '0;
        repeat (3) tick();
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        engine_busy = 1'b0;
        r0 = rd_cnt;
        repeat (15) tick();
        chk(rd_cnt == r0 && !desc_valid, "R10", 256'(rd_cnt - r0), 256'(0));

        // R10: reset stops a fetch in progress
        hw_req[2] = 1'b1; tick(); hw_req = '0;
        repeat (3) tick();
        chk(mem_rd_en, "R10", 256'(mem_rd_en), 256'(1));
        rst_n = 1'b0; tick();
        chk(!mem_rd_en && !desc_valid, "R10", 256'({mem_rd_en, desc_valid}), 256'(0));
        rst_n = 1'b1;
        repeat (15) begin
            tick();
            chk(!desc_valid, "R10", 256'(desc_valid), 256'(0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule